// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor

This block drives an active-low system reset from three sources: power-up, a supply drop and a watchdog that the host has failed to service in time. It runs on a fast system clock and advances its timers only on cycles where a 32.768 kHz enable pulse is present. A digital supply-good flag, which comes from an external comparator, starts a fixed hold period before reset is released. A supply drop forces reset at once.

Once reset is released, the watchdog counts time-base ticks. A two-bit select code picks one of three periods, or turns the watchdog off and parks its counter. The host restarts the count with a single-cycle kick strobe. If the period runs out, reset is asserted for the same fixed hold time, and a status flag marks that the watchdog caused it. All times come from one parameter, the number of ticks in 250 ms (8192 by default). The periods are 7, 3 and 1 times that value.

Top module: `wdt_por_supervisor`

## Requirements
- R1: While `rst_n` is low, `sys_rst_n` is 0 and `wd_bite` is 0.
- R2: When `vdd_ok` is high, reset is released after exactly HOLD ticks (HOLD = TICKS_250MS, default 8192) counted from the start of the hold.
- R3: When `vdd_ok` is low at a clock edge, `sys_rst_n` and `wd_bite` are 0 after that edge, whatever `tick` is. The hold then restarts from zero once `vdd_ok` returns, and this also applies during a watchdog reset.
- R4: The select code sets the watchdog period counted from release: 2'b00 gives 7·HOLD ticks (57344), 2'b01 gives 3·HOLD (24576) and 2'b10 gives HOLD (8192).
- R5: Select code 2'b11 disables the watchdog. The counter stays at zero and no timeout occurs.
- R6: A watchdog timeout asserts reset for exactly HOLD ticks, with `wd_bite` high for all of that time. Reset is then released.
- R7: A `kick` while reset is released restarts the watchdog count from zero. A `kick` while reset is asserted has no effect on the hold or on the following period.
- R8: A change of `wd_sel` restarts the watchdog count. The new period is counted from the clock after the change.
- R9: Hold and watchdog counts advance only on clock edges where `tick` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| tick | input | 1 | 32.768 kHz time-base enable, one clock wide |
| vdd_ok | input | 1 | Supply above trip threshold (from comparator) |
| wd_sel | input | 2 | Watchdog period select |
| kick | input | 1 | Watchdog service strobe |
| sys_rst_n | output | 1 | Active-low system reset |
| wd_bite | output | 1 | High while reset is held because of a watchdog timeout |

## Verification
The bench measures each period and hold length to the exact clock. An off-by-one in the terminal count would show up as a release or timeout one tick early or late. It kicks the block during a watchdog hold, where a design that honoured the kick would shorten the hold or start the next period part-way through. It changes the select code in mid-count and moves from the off code to an active one; a design that kept the old count would time out early. It also drops the supply during a watchdog hold, where a design that resumed the old hold would release after only the remaining ticks and would leave the watchdog flag set.

// File: rtl/wdt_por_supervisor.sv
module wdt_por_supervisor #(
  parameter int TICKS_250MS = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       vdd_ok,
  input  logic [1:0] wd_sel,
  input  logic       kick,
  output logic       sys_rst_n,
  output logic       wd_bite
);
  localparam int P_LONG  = 7 * TICKS_250MS;
  localparam int P_MID   = 3 * TICKS_250MS;
  localparam int P_SHORT = TICKS_250MS;
  localparam int CW      = $clog2(P_LONG + 1);
  localparam int HW      = $clog2(TICKS_250MS + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(TICKS_250MS - 1);

  typedef enum logic [1:0] {ST_HOLD_PWR, ST_RUN, ST_HOLD_WD} st_t;

  st_t           st;
  logic [HW-1:0] hold_cnt;
  logic [CW-1:0] wd_cnt;
  logic [CW-1:0] wd_last;
  logic [1:0]    sel_q;

  wire wd_off  = (sel_q == 2'b11);
  wire sel_chg = (wd_sel != sel_q);

  always_comb begin
    case (sel_q)
      2'b00:   wd_last = CW'(P_LONG - 1);
      2'b01:   wd_last = CW'(P_MID - 1);
      default: wd_last = CW'(P_SHORT - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_HOLD_PWR;
      hold_cnt <= '0;
      wd_cnt   <= '0;
      sel_q    <= 2'b00;
    end else begin
      sel_q <= wd_sel;
      if (!vdd_ok) begin
        st       <= ST_HOLD_PWR;
        hold_cnt <= '0;
        wd_cnt   <= '0;
      end else begin
        case (st)
          ST_RUN: begin
            if (wd_off || sel_chg || kick) begin
              wd_cnt <= '0;
            end else if (tick) begin
              if (wd_cnt == wd_last) begin
                st       <= ST_HOLD_WD;
                wd_cnt   <= '0;
                hold_cnt <= '0;
              end else begin
                wd_cnt <= wd_cnt + 1'b1;
              end
            end
          end
          default: begin
            wd_cnt <= '0;
            if (tick) begin
              if (hold_cnt == HOLD_LAST) begin
                st       <= ST_RUN;
                hold_cnt <= '0;
              end else begin
                hold_cnt <= hold_cnt + 1'b1;
              end
            end
          end
        endcase
      end
    end
  end

  assign sys_rst_n = (st == ST_RUN);
  assign wd_bite   = (st == ST_HOLD_WD);

  // R3
  vdd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vdd_ok |=> (!sys_rst_n && !wd_bite));

  // R6
  bite_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |-> !sys_rst_n);

  // R6
  bite_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_bite) |-> $fell(sys_rst_n));

  // R7
  kick_keeps_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && kick && vdd_ok) |=> sys_rst_n);

  // R5
  off_no_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_n && wd_off && vdd_ok) |=> sys_rst_n);

  // R2
  release_needs_vdd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_n) |-> $past(vdd_ok));

  // R9
  no_tick_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && vdd_ok && !sys_rst_n) |=> !sys_rst_n);

endmodule

// File: tb/wdt_por_supervisor_tb.sv
module wdt_por_supervisor_tb;
  localparam int T = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic vdd_ok = 1'b1;
  logic [1:0] wd_sel = 2'b00;
  logic kick = 1'b0;
  logic sys_rst_n, wd_bite;

  int checks = 0;
  int failures = 0;

  // rows: select code, expected period in ticks (R4)
  localparam int VEC [3][2] = '{'{0, 7*T}, '{1, 3*T}, '{2, T}};

  always #10 clk = ~clk;

  wdt_por_supervisor #(.TICKS_250MS(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .vdd_ok(vdd_ok),
    .wd_sel(wd_sel), .kick(kick), .sys_rst_n(sys_rst_n), .wd_bite(wd_bite)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cnt_until(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sys_rst_n != lvl && n < 1000);
  endtask

  task automatic stay_high(input int cycles, input string req);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!sys_rst_n) lows++;
    end
    check(lows == 0, req, lows, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1
    check(sys_rst_n == 1'b0, "R1 sys_rst_n", sys_rst_n, 0);
    check(wd_bite == 1'b0, "R1 wd_bite", wd_bite, 0);
    rst_n = 1'b1;
    cnt_until(1'b1, n);
    check(n == T, "R2 power-up hold", n, T);

    // R4 / R6 vector walk
    for (int v = 0; v < 3; v++) begin
      vdd_ok = 1'b0;
      wd_sel = 2'(VEC[v][0]);
      @(negedge clk);
      vdd_ok = 1'b1;
      cnt_until(1'b1, n);
      check(n == T, "R2 hold after drop", n, T);
      cnt_until(1'b0, n);
      check(n == VEC[v][1], "R4 period", n, VEC[v][1]);
      check(wd_bite == 1'b1, "R6 flag set", wd_bite, 1);
    end
    cnt_until(1'b1, n);
    check(n == T, "R6 watchdog hold", n, T);

    // R7 kicks keep it running (sel 10, period T)
    for (int k = 0; k < 8; k++) begin
      stay_high(5, "R7 kicked run");
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
    end
    cnt_until(1'b0, n);
    check(n == T, "R7 period after last kick", n, T);
    kick = 1'b1;
    cnt_until(1'b1, n);
    check(n == T, "R7 kick ignored in hold", n, T);
    kick = 1'b0;
    cnt_until(1'b0, n);
    check(n == T, "R7 full period after ignored kick", n, T);

    // R5 off code
    wd_sel = 2'b11;
    cnt_until(1'b1, n);
    check(n == T, "R6 hold", n, T);
    stay_high(300, "R5 disabled");
    // R8 off -> active
    wd_sel = 2'b10;
    cnt_until(1'b0, n);
    check(n == T + 1, "R8 restart from off", n, T + 1);

    // R8 mid-count change
    cnt_until(1'b1, n);
    wd_sel = 2'b00;
    stay_high(20, "R8 long period");
    wd_sel = 2'b01;
    cnt_until(1'b0, n);
    check(n == 3*T + 1, "R8 restart on change", n, 3*T + 1);

    // R9 tick gating in hold and in run
    tick = 1'b0;
    repeat (50) @(negedge clk);
    check(sys_rst_n == 1'b0 && wd_bite == 1'b1, "R9 hold frozen", sys_rst_n, 0);
    tick = 1'b1;
    cnt_until(1'b1, n);
    check(n == T, "R9 hold resumes", n, T);
    tick = 1'b0;
    stay_high(100, "R9 run frozen");
    tick = 1'b1;
    cnt_until(1'b0, n);
    check(n == 3*T, "R9 period after gating", n, 3*T);

    // R3 supply drop
    cnt_until(1'b1, n);
    repeat (3) @(negedge clk);
    tick = 1'b0;
    vdd_ok = 1'b0;
    @(negedge clk);
    check(sys_rst_n == 1'b0, "R3 prompt reset", sys_rst_n, 0);
    tick = 1'b1;
    vdd_ok = 1'b1;
    cnt_until(1'b1, n);
    check(n == T, "R3 hold after drop", n, T);
    cnt_until(1'b0, n);
    check(wd_bite == 1'b1, "R6 flag", wd_bite, 1);
    repeat (3) @(negedge clk);
    vdd_ok = 1'b0;
    @(negedge clk);
    check(wd_bite == 1'b0, "R3 flag cleared", wd_bite, 0);
    check(sys_rst_n == 1'b0, "R3 still in reset", sys_rst_n, 0);
    vdd_ok = 1'b1;
    cnt_until(1'b1, n);
    check(n == T, "R3 hold restarted", n, T);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule